// File: doc/BRIEF.md
# Register Cache Set Allocator

This block decides which set of a set-associative register cache receives a physical register when that register is inserted. The set index is never derived from bits of the register number. Instead, a chooser picks it from live per-set occupancy counts, so that the registers in use are spread evenly over the sets and fewer of them conflict. The block keeps one occupancy counter per set. It also keeps a table that records, for each physical register, whether it is placed and in which set, so that a later release or lookup finds the same set.

Three placement policies are selected through a two-bit code. Plain rotation ignores how full the sets are. Least-occupied placement takes the emptiest set. Thresholded rotation skips sets that have reached a programmable occupancy limit. The cache data arrays sit outside this block. The surrounding logic asks the block for a set when it inserts a register and reports a release when the register leaves the cache.

Top module: `rc_set_alloc`

## Requirements
- R1: After reset every set holds zero registers, no register reads as placed on the lookup port, and the rotation pointer names set 0.
- R2: The chosen set does not depend on the register number: registers whose numbers share their low bits are spread over different sets.
- R3: With policy code 2'b00 the chosen set is the rotation pointer, whatever the occupancy. Each accepted allocation moves the pointer to the chosen set plus one, modulo the set count.
- R4: With policy code 2'b01 the chosen set has the smallest effective occupancy, and ties go to the lowest set index. Allocations in this mode leave the rotation pointer unchanged.
- R5: With policy code 2'b10 the chosen set is the first set, scanning upward from the pointer with wrap-around, whose effective occupancy is strictly below `thresh_i`. The pointer then moves to the chosen set plus one.
- R6: With policy code 2'b10, when no set is below `thresh_i`, the choice falls back to the rotation pointer, as in R3.
- R7: An accepted allocation adds one to the occupancy of the chosen set and records the set. From the next cycle the lookup port reports the register as placed in that set.
- R8: A release of a placed register takes one from the occupancy of its recorded set and clears its entry. From the next cycle the lookup port reports a miss.
- R9: When an allocation and a release fall in the same cycle, both are applied. The choice uses the occupancy as it stands after the release (the effective occupancy).
- R10: An allocation of a register that is already placed is ignored: its mapping, the occupancies and the pointer are unchanged. A release of a register that is not placed is ignored.
- R11: Policy code 2'b11 behaves exactly like code 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Placement policy: 00 rotate, 01 least occupied, 10 thresholded rotate, 11 rotate |
| thresh_i | input | CNT_W | Occupancy limit for thresholded rotation |
| alloc_valid_i | input | 1 | Request to place a register |
| alloc_reg_i | input | REG_W | Physical register to place |
| alloc_set_o | output | SET_W | Set chosen for the current cycle's inputs (combinational) |
| free_valid_i | input | 1 | Request to release a register |
| free_reg_i | input | REG_W | Physical register to release |
| lookup_reg_i | input | REG_W | Register whose placement is queried |
| lookup_hit_o | output | 1 | Queried register is currently placed |
| lookup_set_o | output | SET_W | Set holding the queried register |

## Verification
An allocation and a release can land in the same cycle, and the release must be applied first so that it shapes the choice. The bench provokes this in least-occupied mode. It releases a register from a set that thereby becomes the only emptiest set, and in the same cycle it requests a new register. The tie-breaking rule on the counts before the release would have chosen a different set. The result is judged from the chosen set in that cycle, from lookups of both registers one cycle later, and from a following least-occupied choice that shows the net occupancy.

// File: rtl/rc_alloc_pkg.sv
package rc_alloc_pkg;

   typedef enum logic [1:0] {
      POL_ROTATE     = 2'b00,
      POL_LEAST      = 2'b01,
      POL_THRESH     = 2'b10,
      POL_ROTATE_ALT = 2'b11
   } alloc_pol_e;

endpackage

// File: rtl/rc_map_table.sv
module rc_map_table #(
   parameter int NUM_REGS = 64,
   parameter int NUM_SETS = 4,
   localparam int REG_W   = $clog2(NUM_REGS),
   localparam int SET_W   = $clog2(NUM_SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_reg,
   input  logic [SET_W-1:0] wr_set,
   input  logic             clr_en,
   input  logic [REG_W-1:0] clr_reg,
   input  logic [REG_W-1:0] rd_a_reg,
   output logic             rd_a_vld,
   output logic [SET_W-1:0] rd_a_set,
   input  logic [REG_W-1:0] rd_b_reg,
   output logic             rd_b_vld,
   output logic [SET_W-1:0] rd_b_set,
   input  logic [REG_W-1:0] rd_c_reg,
   output logic             rd_c_vld,
   output logic [SET_W-1:0] rd_c_set
);

   logic [NUM_REGS-1:0]            vld_q;
   logic [NUM_REGS-1:0][SET_W-1:0] set_q;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
            set_q[g] <= '0;
         end else if (wr_en && (wr_reg == REG_W'(g))) begin
            vld_q[g] <= 1'b1;
            set_q[g] <= wr_set;
         end else if (clr_en && (clr_reg == REG_W'(g))) begin
            vld_q[g] <= 1'b0;
         end
      end
   end

   assign rd_a_vld = vld_q[rd_a_reg];
   assign rd_a_set = set_q[rd_a_reg];
   assign rd_b_vld = vld_q[rd_b_reg];
   assign rd_b_set = set_q[rd_b_reg];
   assign rd_c_vld = vld_q[rd_c_reg];
   assign rd_c_set = set_q[rd_c_reg];

endmodule

// File: rtl/rc_occupancy.sv
module rc_occupancy #(
   parameter int NUM_SETS = 4,
   parameter int CNT_W    = 7,
   localparam int SET_W   = $clog2(NUM_SETS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           inc_en,
   input  logic [SET_W-1:0]               inc_set,
   input  logic                           dec_en,
   input  logic [SET_W-1:0]               dec_set,
   output logic [NUM_SETS-1:0][CNT_W-1:0] occ_o,
   output logic [NUM_SETS-1:0][CNT_W-1:0] eff_o
);

   logic [NUM_SETS-1:0][CNT_W-1:0] occ_q;

   for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
      logic dec_here;
      logic inc_here;
      assign dec_here = dec_en && (dec_set == SET_W'(g));
      assign inc_here = inc_en && (inc_set == SET_W'(g));
      // release is applied ahead of the allocation choice
      assign eff_o[g] = occ_q[g] - (dec_here ? CNT_W'(1) : CNT_W'(0));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) occ_q[g] <= '0;
         else        occ_q[g] <= eff_o[g] + (inc_here ? CNT_W'(1) : CNT_W'(0));
      end
   end

   assign occ_o = occ_q;

endmodule

// File: rtl/rc_set_picker.sv
module rc_set_picker
   import rc_alloc_pkg::*;
#(
   parameter int NUM_SETS = 4,
   parameter int CNT_W    = 7,
   localparam int SET_W   = $clog2(NUM_SETS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  alloc_pol_e                     policy_i,
   input  logic [CNT_W-1:0]               thresh_i,
   input  logic [NUM_SETS-1:0][CNT_W-1:0] eff_i,
   input  logic                           adv_en,
   output logic [SET_W-1:0]               set_o
);

   logic [SET_W-1:0]    ptr_q;
   logic [NUM_SETS-1:0] below;
   logic [SET_W-1:0]    least_set;
   logic [CNT_W-1:0]    least_cnt;
   logic [SET_W-1:0]    thr_set;
   logic                thr_found;

   for (genvar g = 0; g < NUM_SETS; g++) begin : g_below
      assign below[g] = eff_i[g] < thresh_i;
   end

   // strict compare keeps the lowest index on ties
   always_comb begin
      least_set = '0;
      least_cnt = eff_i[0];
      for (int i = 1; i < NUM_SETS; i++) begin
         if (eff_i[i] < least_cnt) begin
            least_set = SET_W'(i);
            least_cnt = eff_i[i];
         end
      end
   end

   // scan upward from the pointer, wrapping through the power-of-two range
   always_comb begin
      thr_set   = ptr_q;
      thr_found = 1'b0;
      for (int i = 0; i < NUM_SETS; i++) begin
         logic [SET_W-1:0] idx;
         idx = ptr_q + SET_W'(i);
         if (!thr_found && below[idx]) begin
            thr_set   = idx;
            thr_found = 1'b1;
         end
      end
   end

   always_comb begin
      unique case (policy_i)
         POL_LEAST:  set_o = least_set;
         POL_THRESH: set_o = thr_set;
         default:    set_o = ptr_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ptr_q <= '0;
      else if (adv_en && (policy_i != POL_LEAST)) ptr_q <= set_o + SET_W'(1);
   end

endmodule

// File: rtl/rc_set_alloc.sv
module rc_set_alloc
   import rc_alloc_pkg::*;
#(
   parameter int NUM_REGS = 64,
   parameter int NUM_SETS = 4,
   localparam int REG_W   = $clog2(NUM_REGS),
   localparam int SET_W   = $clog2(NUM_SETS),
   localparam int CNT_W   = $clog2(NUM_REGS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       policy_i,
   input  logic [CNT_W-1:0] thresh_i,
   input  logic             alloc_valid_i,
   input  logic [REG_W-1:0] alloc_reg_i,
   output logic [SET_W-1:0] alloc_set_o,
   input  logic             free_valid_i,
   input  logic [REG_W-1:0] free_reg_i,
   input  logic [REG_W-1:0] lookup_reg_i,
   output logic             lookup_hit_o,
   output logic [SET_W-1:0] lookup_set_o
);

   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("rc_set_alloc: NUM_SETS must be a power of two of at least 2");
   end
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("rc_set_alloc: NUM_REGS must be a power of two of at least 2");
   end

   logic                           alloc_mapped;
   logic [SET_W-1:0]               alloc_old_set;
   logic                           free_mapped;
   logic [SET_W-1:0]               free_set;
   logic                           alloc_fire;
   logic                           free_fire;
   logic [NUM_SETS-1:0][CNT_W-1:0] occ;
   logic [NUM_SETS-1:0][CNT_W-1:0] eff;
   logic [SET_W-1:0]               pick;
   alloc_pol_e                     pol;

   assign pol        = alloc_pol_e'(policy_i);
   assign alloc_fire = alloc_valid_i && !alloc_mapped;
   assign free_fire  = free_valid_i && free_mapped;
   assign alloc_set_o = pick;

   rc_map_table #(
      .NUM_REGS (NUM_REGS),
      .NUM_SETS (NUM_SETS)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (alloc_fire),
      .wr_reg   (alloc_reg_i),
      .wr_set   (pick),
      .clr_en   (free_fire),
      .clr_reg  (free_reg_i),
      .rd_a_reg (alloc_reg_i),
      .rd_a_vld (alloc_mapped),
      .rd_a_set (alloc_old_set),
      .rd_b_reg (free_reg_i),
      .rd_b_vld (free_mapped),
      .rd_b_set (free_set),
      .rd_c_reg (lookup_reg_i),
      .rd_c_vld (lookup_hit_o),
      .rd_c_set (lookup_set_o)
   );

   rc_occupancy #(
      .NUM_SETS (NUM_SETS),
      .CNT_W    (CNT_W)
   ) u_occ (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (alloc_fire),
      .inc_set (pick),
      .dec_en  (free_fire),
      .dec_set (free_set),
      .occ_o   (occ),
      .eff_o   (eff)
   );

   rc_set_picker #(
      .NUM_SETS (NUM_SETS),
      .CNT_W    (CNT_W)
   ) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .policy_i (pol),
      .thresh_i (thresh_i),
      .eff_i    (eff),
      .adv_en   (alloc_fire),
      .set_o    (pick)
   );

   // the old set of a re-allocated register is deliberately not used
   logic unused_old;
   assign unused_old = ^alloc_old_set;

endmodule

// File: rtl/rc_set_alloc_chk.sv
module rc_set_alloc_chk
   import rc_alloc_pkg::*;
#(
   parameter int NUM_REGS = 64,
   parameter int NUM_SETS = 4,
   localparam int REG_W   = $clog2(NUM_REGS),
   localparam int SET_W   = $clog2(NUM_SETS),
   localparam int CNT_W   = $clog2(NUM_REGS + 1)
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [1:0]                     policy_i,
   input logic [CNT_W-1:0]               thresh_i,
   input logic                           alloc_fire,
   input logic [REG_W-1:0]               alloc_reg_i,
   input logic [SET_W-1:0]               alloc_set_o,
   input logic                           free_fire,
   input logic [SET_W-1:0]               free_set,
   input logic [NUM_SETS-1:0][CNT_W-1:0] occ,
   input logic [NUM_SETS-1:0][CNT_W-1:0] eff,
   input logic [REG_W-1:0]               lookup_reg_i,
   input logic                           lookup_hit_o,
   input logic [SET_W-1:0]               lookup_set_o
);

   logic [SET_W-1:0] exp_ptr;
   logic             is_rot;
   logic             min_ok;
   logic             any_below;
   logic [CNT_W-1:0] occ_at_alloc;
   logic [CNT_W-1:0] occ_at_free;

   assign is_rot       = (policy_i == POL_ROTATE) || (policy_i == POL_ROTATE_ALT);
   assign occ_at_alloc = occ[alloc_set_o];
   assign occ_at_free  = occ[free_set];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  exp_ptr <= '0;
      else if (alloc_fire && policy_i != POL_LEAST) exp_ptr <= alloc_set_o + SET_W'(1);
   end

   always_comb begin
      min_ok    = 1'b1;
      any_below = 1'b0;
      for (int j = 0; j < NUM_SETS; j++) begin
         if (eff[j] < eff[alloc_set_o]) min_ok = 1'b0;
         if (eff[j] == eff[alloc_set_o] && SET_W'(j) < alloc_set_o) min_ok = 1'b0;
         if (eff[j] < thresh_i) any_below = 1'b1;
      end
   end

   a_r3_rotate_step: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_fire && is_rot) |-> (alloc_set_o == exp_ptr));

   a_r4_least_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_fire && policy_i == POL_LEAST) |-> min_ok);

   a_r5_thresh_below: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_fire && policy_i == POL_THRESH && any_below) |-> (eff[alloc_set_o] < thresh_i));

   a_r6_thresh_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_fire && policy_i == POL_THRESH && !any_below) |-> (alloc_set_o == exp_ptr));

   a_r7_occ_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_fire && !free_fire) |=> (occ[$past(alloc_set_o)] == $past(occ_at_alloc) + CNT_W'(1)));

   a_r7_lookup_after_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_fire |=> (!(lookup_reg_i == $past(alloc_reg_i)) ||
                      (lookup_hit_o && lookup_set_o == $past(alloc_set_o))));

   a_r8_occ_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (free_fire && !alloc_fire) |=> (occ[$past(free_set)] == $past(occ_at_free) - CNT_W'(1)));

endmodule

bind rc_set_alloc rc_set_alloc_chk #(
   .NUM_REGS (NUM_REGS),
   .NUM_SETS (NUM_SETS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .policy_i     (policy_i),
   .thresh_i     (thresh_i),
   .alloc_fire   (alloc_fire),
   .alloc_reg_i  (alloc_reg_i),
   .alloc_set_o  (alloc_set_o),
   .free_fire    (free_fire),
   .free_set     (free_set),
   .occ          (occ),
   .eff          (eff),
   .lookup_reg_i (lookup_reg_i),
   .lookup_hit_o (lookup_hit_o),
   .lookup_set_o (lookup_set_o)
);

// File: tb/rc_set_alloc_tb.sv
module rc_set_alloc_tb;

   localparam int NUM_REGS = 64;
   localparam int NUM_SETS = 4;
   localparam int REG_W    = $clog2(NUM_REGS);
   localparam int SET_W    = $clog2(NUM_SETS);
   localparam int CNT_W    = $clog2(NUM_REGS + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       policy_i = 2'b00;
   logic [CNT_W-1:0] thresh_i = '0;
   logic             alloc_valid_i = 1'b0;
   logic [REG_W-1:0] alloc_reg_i = '0;
   logic [SET_W-1:0] alloc_set_o;
   logic             free_valid_i = 1'b0;
   logic [REG_W-1:0] free_reg_i = '0;
   logic [REG_W-1:0] lookup_reg_i = '0;
   logic             lookup_hit_o;
   logic [SET_W-1:0] lookup_set_o;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   rc_set_alloc #(
      .NUM_REGS (NUM_REGS),
      .NUM_SETS (NUM_SETS)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .policy_i      (policy_i),
      .thresh_i      (thresh_i),
      .alloc_valid_i (alloc_valid_i),
      .alloc_reg_i   (alloc_reg_i),
      .alloc_set_o   (alloc_set_o),
      .free_valid_i  (free_valid_i),
      .free_reg_i    (free_reg_i),
      .lookup_reg_i  (lookup_reg_i),
      .lookup_hit_o  (lookup_hit_o),
      .lookup_set_o  (lookup_set_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // allocation (optionally with a release in the same cycle)
   task automatic step(input string req, input logic [1:0] pol, input bit do_alloc,
                       input int areg, input bit do_free, input int freg, input int exp_set);
      @(negedge clk);
      policy_i      = pol;
      alloc_valid_i = do_alloc;
      alloc_reg_i   = REG_W'(areg);
      free_valid_i  = do_free;
      free_reg_i    = REG_W'(freg);
      #1;
      if (exp_set >= 0) chk(req, int'(alloc_set_o), exp_set);
      @(posedge clk);
      #1;
      alloc_valid_i = 1'b0;
      free_valid_i  = 1'b0;
   endtask

   task automatic look(input string req, input int r, input bit exp_hit, input int exp_set);
      @(negedge clk);
      lookup_reg_i = REG_W'(r);
      #1;
      chk(req, int'(lookup_hit_o), int'(exp_hit));
      if (exp_hit) chk(req, int'(lookup_set_o), exp_set);
   endtask

   task automatic peek(input string req, input logic [1:0] pol, input int exp_set);
      @(negedge clk);
      policy_i = pol;
      #1;
      chk(req, int'(alloc_set_o), exp_set);
   endtask

   task automatic t_reset;
      look("R1 no mapping", 0, 1'b0, 0);
      look("R1 no mapping", 63, 1'b0, 0);
      peek("R1 pointer at 0", 2'b00, 0);
      peek("R1 all sets empty", 2'b01, 0);
   endtask

   // same low bits, different sets; counts end at [2,1,1,1], pointer 1
   task automatic t_rotate;
      step("R2 R3 rotate", 2'b00, 1, 0,  0, 0, 0);
      step("R2 R3 rotate", 2'b00, 1, 4,  0, 0, 1);
      step("R2 R3 rotate", 2'b00, 1, 8,  0, 0, 2);
      step("R2 R3 rotate", 2'b00, 1, 12, 0, 0, 3);
      step("R3 wrap",      2'b00, 1, 16, 0, 0, 0);
      look("R7 lookup", 16, 1'b1, 0);
      look("R7 lookup", 4,  1'b1, 1);
   endtask

   // ties to lowest; pointer left at 1; then rotate ignores occupancy
   task automatic t_least;
      step("R4 least tie", 2'b01, 1, 20, 0, 0, 1);
      step("R4 least",     2'b01, 1, 21, 0, 0, 2);
      step("R4 least",     2'b01, 1, 22, 0, 0, 3);
      step("R4 least all tie", 2'b01, 1, 23, 0, 0, 0);
      step("R4 pointer kept, R3 ignores fill", 2'b00, 1, 24, 0, 0, 1);
   endtask

   // counts [3,3,2,2], pointer 2
   task automatic t_ignored;
      step("R10 remapping ignored", 2'b00, 1, 24, 0, 0, 2);
      look("R10 mapping kept", 24, 1'b1, 1);
      peek("R10 pointer not moved", 2'b00, 2);
      step("R10 release of unplaced", 2'b00, 0, 0, 1, 40, -1);
      peek("R10 counts unchanged", 2'b01, 2);
   endtask

   // counts go to [1,3,2,2]
   task automatic t_release;
      step("R8 release", 2'b00, 0, 0, 1, 0, -1);
      look("R8 entry cleared", 0, 1'b0, 0);
      step("R8 release", 2'b00, 0, 0, 1, 16, -1);
      peek("R8 count dropped", 2'b01, 0);
   endtask

   task automatic t_thresh;
      thresh_i = CNT_W'(2);
      step("R5 skip full sets", 2'b10, 1, 30, 0, 0, 0);
      step("R6 none below",     2'b10, 1, 31, 0, 0, 1);
      thresh_i = CNT_W'(3);
      step("R5 first below",    2'b10, 1, 32, 0, 0, 2);
   endtask

   // counts [2,4,3,2]; release reg 12 from set 3 while allocating 33
   task automatic t_same_cycle;
      step("R9 post-release choice", 2'b01, 1, 33, 1, 12, 3);
      look("R9 release applied", 12, 1'b0, 0);
      look("R9 alloc applied", 33, 1'b1, 3);
      peek("R9 net occupancy", 2'b01, 0);
   endtask

   // pointer 3 after last thresholded pick
   task automatic t_alt_code;
      step("R11 code 3 rotates", 2'b11, 1, 34, 0, 0, 3);
      step("R11 code 3 wraps",   2'b11, 1, 35, 0, 0, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_rotate();
      t_least();
      t_ignored();
      t_release();
      t_thresh();
      t_same_cycle();
      t_alt_code();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule